// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block watches a single asynchronous serial line and turns every frame it carries into a stream of typed events. The line rests high. A frame opens with a low start bit, carries five to nine data bits, may carry one parity bit, and closes with a stop bit. The receiver re-times the line into its own clock domain and detects the falling edge that opens a frame. It then samples each bit near its centre, using a runtime divisor given in clocks per bit.

Each field of the frame is reported as its own event. An event is a one-cycle valid pulse with a 3-bit kind code and a payload as wide as the longest data word. Faults do not abort the frame. A start bit that reads high, a stop bit that reads low and a parity mismatch are each flagged by an error event, and reception goes on to the end of the frame. Every setting (divisor, data length, parity mode, bit order, parity-check enable) is captured when a frame opens, so a change made while a frame is in flight does not affect that frame.

Top module: `serial_frame_rx`

## Requirements
- R1: The line passes through two synchronizing flops. The first synchronized sample after reset only seeds the previous-value register. A frame opens only when a previous sample of 1 is followed by a sample of 0, so a line held low from reset onward produces no event.
- R2: Bit k of a frame (k=0 is the start bit) is sampled half a bit period plus k bit periods after the opening edge. The event for that sample appears 3 + D/2 + k·D clock cycles after the clock edge at which the line was first driven low, where D is the divisor in clocks per bit. A divisor below 4 is treated as 4.
- R3: A start bit read as 0 gives a start event (kind 0, payload 0). A start bit read as 1 gives an invalid-start event (kind 4, payload 1), then a start event (kind 0, payload 1) in the next cycle, and the rest of the frame is still received.
- R4: The data length input selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. After the last data bit is sampled, one data event (kind 1) carries the assembled word, right-aligned, with all unused upper bits zero.
- R5: With the bit-order input at 0 the first data bit on the line is the word's bit 0. With the input at 1 the first data bit is the word's most significant bit.
- R6: Parity mode codes: 0 none, 1 odd, 2 even, 3 always-0, 4 always-1. Codes 5 to 7 act as none. With no parity, no parity event is produced and the stop bit is taken at position N+1.
- R7: A parity bit that passes gives a parity event (kind 2, payload the parity bit). Odd parity passes when the count of ones in the data plus the parity bit is odd, even parity when that count is even, and the fixed modes when the bit equals 0 or 1 respectively. A failing bit with checking enabled gives a parity-error event (kind 6) whose payload bit 1 is the expected value and bit 0 the received value.
- R8: With the parity-check enable at 0, the parity bit is always reported as a parity event (kind 2) and never as an error.
- R9: A stop bit read as 1 gives a stop event (kind 3, payload 1). A stop bit read as 0 gives an invalid-stop event (kind 5, payload 0), then a stop event (kind 3, payload 0) in the next cycle. After the stop bit the receiver waits for a new falling edge.
- R10: All settings are captured when a frame opens. Changes during a frame have no effect on that frame's events or timing.
- R11: The valid output is a single-cycle pulse carrying at most one event per cycle, with kind codes only 0 to 6. A frame's events arrive in the order start, data, parity, stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous serial line, idle high |
| clks_per_bit_i | input | DIV_W (16) | Bit period in clock cycles (minimum 4) |
| data_len_i | input | 4 | Number of data bits, 5 to 9 |
| parity_mode_i | input | 3 | Parity mode code (R6) |
| msb_first_i | input | 1 | 1 = most significant data bit first |
| par_check_en_i | input | 1 | 1 = report parity mismatches as errors |
| evt_valid_o | output | 1 | One-cycle event strobe |
| evt_kind_o | output | 3 | Event kind code (R3, R4, R7, R9) |
| evt_payload_o | output | WORD_W (9) | Event payload |

## Verification
An invalid-start event and its start event come from the same bit sample, and so do an invalid-stop event and its stop event. Both pairs would compete for the single event output in one cycle. The bench provokes the first case with a one-clock low pulse on an idle line, so the mid-bit start sample reads high. It provokes the second by holding the line low through the stop bit. In each case it checks that the error event comes first, that its companion follows in the very next cycle with the right payload, and that the data event between them and the rest of the frame are intact.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        EV_START     = 3'd0,
        EV_DATA      = 3'd1,
        EV_PARITY    = 3'd2,
        EV_STOP      = 3'd3,
        EV_BAD_START = 3'd4,
        EV_BAD_STOP  = 3'd5,
        EV_PAR_ERR   = 3'd6
    } ev_kind_e;

    typedef enum logic [2:0] {
        PM_NONE  = 3'd0,
        PM_ODD   = 3'd1,
        PM_EVEN  = 3'd2,
        PM_SPACE = 3'd3,
        PM_MARK  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    // Unknown parity codes fall back to "no parity bit".
    function automatic par_mode_e fit_mode(input logic [2:0] code);
        return (code > 3'd4) ? PM_NONE : par_mode_e'(code);
    endfunction

endpackage

// File: rtl/rxf_line_sync.sv
module rxf_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic bit_o,
    output logic fall_o
);
    localparam int WARM_W = $clog2(STAGES + 2);
    localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(STAGES + 1);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;
    logic [WARM_W-1:0] warm_d, warm_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign sync_d[g] = line_i;
        end else begin : g_next
            assign sync_d[g] = sync_q[g-1];
        end
    end

    always_comb begin
        prev_d = sync_q[STAGES-1];
        warm_d = (warm_q == WARM_DONE) ? warm_q : warm_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '1;
            prev_q <= 1'b1;
            warm_q <= '0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
            warm_q <= warm_d;
        end
    end

    assign bit_o  = sync_q[STAGES-1];
    // Only once prev_q holds a genuine line sample may an edge be declared.
    assign fall_o = (warm_q == WARM_DONE) && prev_q && !bit_o;

    AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o); // R1

endmodule

// File: rtl/rxf_bit_timer.sv
module rxf_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == DIV_W'(1));
        if (arm_i) begin
            cnt_d = div_i >> 1;          // first stop lands mid start bit
        end else if (tick_o) begin
            cnt_d = div_i;               // full period to the next centre
        end else if (run_i) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TIMER_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/rxf_parity_eval.sv
module rxf_parity_eval
    import rxf_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  par_mode_e         mode_i,
    input  logic              bit_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              expect_o,
    output logic              pass_o
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^data_i;
        case (mode_i)
            PM_ODD:   expect_o = ~ones_odd;
            PM_EVEN:  expect_o = ones_odd;
            PM_SPACE: expect_o = 1'b0;
            PM_MARK:  expect_o = 1'b1;
            default:  expect_o = bit_i;
        endcase
        pass_o = (expect_o == bit_i);
    end

endmodule

// File: rtl/rxf_event_out.sv
module rxf_event_out
    import rxf_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              put_i,
    input  ev_kind_e          put_kind_i,
    input  logic [WORD_W-1:0] put_pay_i,
    input  logic              also_i,
    input  ev_kind_e          also_kind_i,
    input  logic [WORD_W-1:0] also_pay_i,
    output logic              valid_o,
    output logic [2:0]        kind_o,
    output logic [WORD_W-1:0] pay_o
);
    typedef struct packed {
        logic              vld;
        ev_kind_e          kind;
        logic [WORD_W-1:0] pay;
    } slot_t;

    localparam slot_t SLOT_RST = '{vld: 1'b0, kind: EV_START, pay: '0};

    slot_t out_d, out_q, pend_d, pend_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        pend_d    = pend_q;
        if (put_i) begin
            out_d = '{vld: 1'b1, kind: put_kind_i, pay: put_pay_i};
            if (also_i) begin
                pend_d = '{vld: 1'b1, kind: also_kind_i, pay: also_pay_i};
            end
        end else if (pend_q.vld) begin
            out_d      = pend_q;
            pend_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q  <= SLOT_RST;
            pend_q <= SLOT_RST;
        end else begin
            out_q  <= out_d;
            pend_q <= pend_d;
        end
    end

    assign valid_o = out_q.vld;
    assign kind_o  = out_q.kind;
    assign pay_o   = out_q.pay;

    AST_NO_LOST_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        put_i |-> !pend_q.vld); // R11
    AST_PEND_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_q.vld |=> (!pend_q.vld && valid_o)); // R11

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import rxf_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int WORD_W  = 9,
    parameter int MIN_LEN = 5,
    parameter int MIN_DIV = 4
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            line_i,
    input  logic [DIV_W-1:0]                clks_per_bit_i,
    input  logic [$clog2(WORD_W+1)-1:0]     data_len_i,
    input  logic [2:0]                      parity_mode_i,
    input  logic                            msb_first_i,
    input  logic                            par_check_en_i,
    output logic                            evt_valid_o,
    output logic [2:0]                      evt_kind_o,
    output logic [WORD_W-1:0]               evt_payload_o
);
    localparam int LEN_W = $clog2(WORD_W + 1);

    typedef struct packed {
        rx_state_e         st;
        logic [DIV_W-1:0]  div;
        logic [LEN_W-1:0]  len;
        par_mode_e         pm;
        logic              msb;
        logic              chk;
        logic [LEN_W-1:0]  idx;
        logic [WORD_W-1:0] word;
    } core_t;

    localparam core_t CORE_RST = '{st: ST_IDLE, div: '0, len: '0, pm: PM_NONE,
                                   msb: 1'b0, chk: 1'b0, idx: '0, word: '0};

    function automatic logic [DIV_W-1:0] fit_div(input logic [DIV_W-1:0] v);
        return (v < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : v;
    endfunction

    function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] v);
        if (v < LEN_W'(MIN_LEN)) return LEN_W'(MIN_LEN);
        if (v > LEN_W'(WORD_W))  return LEN_W'(WORD_W);
        return v;
    endfunction

    core_t             c_d, c_q;
    logic              line_bit, line_fall, tick, arm;
    logic [DIV_W-1:0]  timer_div;
    logic              par_expect, par_pass;
    logic [WORD_W-1:0] shifted;
    logic              put, also;
    ev_kind_e          put_kind, also_kind;
    logic [WORD_W-1:0] put_pay, also_pay;

    rxf_line_sync #(.STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (line_i),
        .bit_o  (line_bit),
        .fall_o (line_fall)
    );

    assign timer_div = arm ? fit_div(clks_per_bit_i) : c_q.div;

    rxf_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (arm),
        .run_i  (c_q.st != ST_IDLE),
        .div_i  (timer_div),
        .tick_o (tick)
    );

    rxf_parity_eval #(.WORD_W(WORD_W)) u_par (
        .mode_i   (c_q.pm),
        .bit_i    (line_bit),
        .data_i   (c_q.word),
        .expect_o (par_expect),
        .pass_o   (par_pass)
    );

    always_comb begin
        c_d       = c_q;
        arm       = 1'b0;
        put       = 1'b0;
        put_kind  = EV_START;
        put_pay   = '0;
        also      = 1'b0;
        also_kind = EV_START;
        also_pay  = '0;
        if (c_q.msb) begin
            shifted = {c_q.word[WORD_W-2:0], line_bit};
        end else begin
            shifted = (c_q.word >> 1) | (WORD_W'(line_bit) << (c_q.len - 1'b1));
        end

        case (c_q.st)
            ST_IDLE: begin
                if (line_fall) begin
                    arm      = 1'b1;
                    c_d.st   = ST_START;
                    c_d.div  = fit_div(clks_per_bit_i);
                    c_d.len  = fit_len(data_len_i);
                    c_d.pm   = fit_mode(parity_mode_i);
                    c_d.msb  = msb_first_i;
                    c_d.chk  = par_check_en_i;
                    c_d.idx  = '0;
                    c_d.word = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    put    = 1'b1;
                    c_d.st = ST_DATA;
                    if (line_bit) begin
                        put_kind  = EV_BAD_START;
                        put_pay   = WORD_W'(1);
                        also      = 1'b1;
                        also_kind = EV_START;
                        also_pay  = WORD_W'(1);
                    end else begin
                        put_kind  = EV_START;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    c_d.word = shifted;
                    if (c_q.idx == c_q.len - 1'b1) begin
                        put      = 1'b1;
                        put_kind = EV_DATA;
                        put_pay  = shifted;
                        c_d.st   = (c_q.pm == PM_NONE) ? ST_STOP : ST_PAR;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    put    = 1'b1;
                    c_d.st = ST_STOP;
                    if (!par_pass && c_q.chk) begin
                        put_kind = EV_PAR_ERR;
                        put_pay  = WORD_W'({par_expect, line_bit});
                    end else begin
                        put_kind = EV_PARITY;
                        put_pay  = WORD_W'(line_bit);
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    put    = 1'b1;
                    c_d.st = ST_IDLE;
                    if (!line_bit) begin
                        put_kind  = EV_BAD_STOP;
                        also      = 1'b1;
                        also_kind = EV_STOP;
                    end else begin
                        put_kind  = EV_STOP;
                        put_pay   = WORD_W'(1);
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= CORE_RST;
        end else begin
            c_q <= c_d;
        end
    end

    rxf_event_out #(.WORD_W(WORD_W)) u_evt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .put_i       (put),
        .put_kind_i  (put_kind),
        .put_pay_i   (put_pay),
        .also_i      (also),
        .also_kind_i (also_kind),
        .also_pay_i  (also_pay),
        .valid_o     (evt_valid_o),
        .kind_o      (evt_kind_o),
        .pay_o       (evt_payload_o)
    );

    AST_KIND_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_valid_o |-> (evt_kind_o <= 3'd6)); // R11
    AST_BAD_START_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_o && evt_kind_o == 3'd4) |=>
        (evt_valid_o && evt_kind_o == 3'd0 && evt_payload_o == WORD_W'(1))); // R3
    AST_BAD_STOP_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_o && evt_kind_o == 3'd5) |=>
        (evt_valid_o && evt_kind_o == 3'd3 && evt_payload_o == '0)); // R9
    AST_PARERR_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_o && evt_kind_o == 3'd6) |->
        (evt_payload_o[1] != evt_payload_o[0] && evt_payload_o[WORD_W-1:2] == '0)); // R7
    AST_STOP_ENDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_o && evt_kind_o == 3'd3) |-> (c_q.st == ST_IDLE)); // R9
    AST_SETTINGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.st != ST_IDLE && $past(c_q.st) != ST_IDLE) |->
        ($stable(c_q.div) && $stable(c_q.len) && $stable(c_q.pm) &&
         $stable(c_q.msb) && $stable(c_q.chk))); // R10

endmodule

// File: tb/serial_frame_rx_tb.sv
`timescale 1ns/1ps
module serial_frame_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b0;
    logic [15:0] div_s = 16'd16;
    logic [3:0]  len_s = 4'd8;
    logic [2:0]  pm_s = 3'd0;
    logic        msb_s = 1'b0;
    logic        chk_s = 1'b1;
    logic        evt_valid_o;
    logic [2:0]  evt_kind_o;
    logic [8:0]  evt_payload_o;

    int n_chk = 0, n_fail = 0, cyc = 0, ev_n = 0;
    int ev_kind[64], ev_pay[64], ev_cyc[64];
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_frame_rx dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .line_i         (line),
        .clks_per_bit_i (div_s),
        .data_len_i     (len_s),
        .parity_mode_i  (pm_s),
        .msb_first_i    (msb_s),
        .par_check_en_i (chk_s),
        .evt_valid_o    (evt_valid_o),
        .evt_kind_o     (evt_kind_o),
        .evt_payload_o  (evt_payload_o)
    );

    always @(negedge clk) begin
        if (rst_n && evt_valid_o && ev_n < 64) begin
            ev_kind[ev_n] = int'(evt_kind_o);
            ev_pay[ev_n]  = int'(evt_payload_o);
            ev_cyc[ev_n]  = cyc;
            ev_n = ev_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compares event i as kind*1000+payload.
    task automatic exp_ev(input int i, input int kind, input int pay, input string tag);
        int act;
        act = (i < ev_n) ? ev_kind[i] * 1000 + ev_pay[i] : -1;
        chk(act == kind * 1000 + pay, tag, act, kind * 1000 + pay);
    endtask

    task automatic set_cfg(input int dv, input int ln, input int pm, input bit msb, input bit ck);
        @(negedge clk);
        div_s = 16'(dv); len_s = 4'(ln); pm_s = 3'(pm); msb_s = msb; chk_s = ck;
        repeat (4) @(negedge clk);
        ev_n = 0;
    endtask

    // par_bit < 0: no parity bit on the line. Called at a negedge with line idle high.
    task automatic send_frame(input int word, input int len, input bit msb, input int par_bit,
                              input bit start_ok, input bit stop_val, input int bp,
                              output int fall_cyc);
        line = 1'b0;
        fall_cyc = cyc;
        if (start_ok) begin
            repeat (bp) @(negedge clk);
        end else begin
            @(negedge clk);
            line = 1'b1;
            repeat (bp - 1) @(negedge clk);
        end
        for (int i = 0; i < len; i++) begin
            line = msb ? word[len-1-i] : word[i];
            repeat (bp) @(negedge clk);
        end
        if (par_bit >= 0) begin
            line = par_bit[0];
            repeat (bp) @(negedge clk);
        end
        line = stop_val;
        repeat (bp) @(negedge clk);
        line = 1'b1;
        repeat (3 * bp) @(negedge clk);
    endtask

    task automatic t_reset();
        int f;
        line = 1'b0;
        repeat (5) @(negedge clk);
        chk(evt_valid_o == 1'b0, "R11 reset valid", int'(evt_valid_o), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(ev_n == 0, "R1 low-from-reset no events", ev_n, 0);
        line = 1'b1;
        repeat (20) @(negedge clk);
        chk(ev_n == 0, "R1 rising edge no events", ev_n, 0);
        f = 0;
    endtask

    task automatic t_basic();
        int f;
        set_cfg(16, 8, 0, 0, 1);
        send_frame(32'hA5, 8, 0, -1, 1, 1, 16, f);
        chk(ev_n == 3, "R6 no-parity event count", ev_n, 3);
        exp_ev(0, 0, 0, "R3 start event");
        exp_ev(1, 1, 32'hA5, "R4 data lsb 0xA5");
        exp_ev(2, 3, 1, "R9 stop event");
        chk(ev_cyc[0] == f + 11, "R2 start sample time", ev_cyc[0] - f, 11);
        chk(ev_cyc[2] == f + 155, "R2 stop at N+1 time", ev_cyc[2] - f, 155);
    endtask

    task automatic t_msb_clamp();
        int f;
        // divisor 2 acts as 4, length 15 acts as 9, mode 7 acts as none
        set_cfg(2, 15, 7, 1, 1);
        send_frame(32'h1C3, 9, 1, -1, 1, 1, 4, f);
        chk(ev_n == 3, "R6 mode 7 as none count", ev_n, 3);
        exp_ev(1, 1, 32'h1C3, "R5 msb-first 9-bit data (R4 clamp)");
        chk(ev_cyc[2] == f + 45, "R2 divisor clamp stop time", ev_cyc[2] - f, 45);
    endtask

    task automatic t_parity();
        int f;
        set_cfg(16, 5, 1, 0, 1);
        send_frame(32'h13, 5, 0, 0, 1, 1, 16, f);
        chk(ev_n == 4, "R7 odd frame count", ev_n, 4);
        exp_ev(1, 1, 32'h13, "R4 5-bit data");
        exp_ev(2, 2, 0, "R7 odd pass");
        exp_ev(3, 3, 1, "R11 stop after parity");
        set_cfg(16, 8, 2, 0, 1);
        send_frame(32'h55, 8, 0, 1, 1, 1, 16, f);
        exp_ev(2, 6, 1, "R7 even fail exp0 act1");
        set_cfg(16, 8, 4, 0, 1);
        send_frame(32'h0F, 8, 0, 0, 1, 1, 16, f);
        exp_ev(2, 6, 2, "R7 mark fail exp1 act0");
        set_cfg(16, 8, 3, 0, 1);
        send_frame(32'h0F, 8, 0, 0, 1, 1, 16, f);
        exp_ev(2, 2, 0, "R7 space pass");
    endtask

    task automatic t_check_off();
        int f;
        set_cfg(16, 8, 2, 0, 0);
        send_frame(32'h55, 8, 0, 1, 1, 1, 16, f);
        chk(ev_n == 4, "R8 count", ev_n, 4);
        exp_ev(2, 2, 1, "R8 check off reports parity");
    endtask

    task automatic t_bad_start();
        int f;
        set_cfg(16, 8, 0, 0, 1);
        send_frame(32'h3C, 8, 0, -1, 0, 1, 16, f);
        chk(ev_n == 4, "R3 invalid start count", ev_n, 4);
        exp_ev(0, 4, 1, "R3 invalid start");
        exp_ev(1, 0, 1, "R3 start after invalid");
        chk(ev_cyc[1] == ev_cyc[0] + 1, "R11 companion next cycle", ev_cyc[1] - ev_cyc[0], 1);
        exp_ev(2, 1, 32'h3C, "R3 data still received");
        exp_ev(3, 3, 1, "R3 stop still received");
    endtask

    task automatic t_bad_stop();
        int f;
        set_cfg(16, 8, 0, 0, 1);
        send_frame(32'h81, 8, 0, -1, 1, 0, 16, f);
        chk(ev_n == 4, "R9 invalid stop count", ev_n, 4);
        exp_ev(1, 1, 32'h81, "R9 data before bad stop");
        exp_ev(2, 5, 0, "R9 invalid stop");
        exp_ev(3, 3, 0, "R9 stop after invalid");
        chk(ev_cyc[3] == ev_cyc[2] + 1, "R9 companion next cycle", ev_cyc[3] - ev_cyc[2], 1);
        send_frame(32'h42, 8, 0, -1, 1, 1, 16, f);
        exp_ev(5, 1, 32'h42, "R9 next frame after bad stop");
    endtask

    task automatic t_latch();
        int f;
        set_cfg(16, 8, 0, 0, 1);
        fork
            send_frame(32'h6B, 8, 0, -1, 1, 1, 16, f);
            begin
                repeat (48) @(negedge clk);
                div_s = 16'd5; len_s = 4'd5; pm_s = 3'd2; msb_s = 1'b1;
            end
        join
        chk(ev_n == 3, "R10 count unchanged", ev_n, 3);
        exp_ev(1, 1, 32'h6B, "R10 data unchanged");
        chk(ev_cyc[2] == f + 155, "R10 timing unchanged", ev_cyc[2] - f, 155);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_msb_clamp();
        t_parity();
        t_check_off();
        t_bad_start();
        t_bad_stop();
        t_latch();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule